// File: doc/BRIEF.md
# Pin-mapping configuration lock with shadow monitor

This block holds a bank of pin-mapping configuration registers (a group of input-map registers and a group of output-map registers) and guards them with a lock bit. Software reaches the bank and a control byte through a plain register bus. That bus has an address, a byte of write data, a write strobe and a combinational read-back path. Writes to the bank take effect only while the lock bit is clear. While it is set, they finish normally on the bus but change nothing.

The lock bit changes only through a three-write ritual on the control byte: a first key byte, a second key byte, then the byte that carries the new lock value. A configuration input selects one-way mode, in which a set lock can no longer be cleared until the next reset. Every protected register has a shadow copy. A comparator checks each live register against its shadow on every cycle and raises a reset request when any pair differs. A test input can flip one live bit so the monitor can be exercised.

Top module: `pinmap_guard`

## Requirements
- R1: After reset the lock bit is 0, every protected register reads 0, the mismatch reset request is 0 and the key tracker is idle.
- R2: Address 0 reads the control byte, with the lock bit at bit 6 and all other bits 0. Addresses 1..N_IN read the input-map registers and N_IN+1..N_IN+N_OUT read the output-map registers. Any other address reads 0, and writes to it change nothing.
- R3: While the lock bit is 0, a write to a protected address updates that register. The new value reads back from the next cycle on, and the write never raises the mismatch request.
- R4: While the lock bit is 1, writes to protected addresses leave every protected register unchanged.
- R5: The lock bit takes bit 6 of the byte written to address 0 only when that write directly follows a write of 0x46 and then a write of 0x57 to address 0. No other write changes the lock bit.
- R6: Any write to address 0 other than the expected key byte cancels the sequence. A write of 0x46 always starts the sequence again from its first step.
- R7: The lock bit keeps its value across any number of protected-register writes, so one unlock permits many updates.
- R8: With the one-way input at 1, a set lock bit cannot be cleared, even by a complete key sequence. Setting the lock still works.
- R9: With the one-way input at 0, the lock can be set and cleared any number of times, each change needing its own key sequence.
- R10: If a live register differs from its shadow, the mismatch reset request is 1 in the cycle after the difference appears. It stays 1 while the difference lasts and falls one cycle after a legal write restores agreement.
- R11: The fault input XORs a one-hot bit mask into the selected live register and leaves its shadow untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address (0 = control byte) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| oneway_cfg_i | input | 1 | 1 = lock can be set but never cleared |
| fault_en_i | input | 1 | Test: flip one live bit this cycle |
| fault_sel_i | input | SEL_W | Test: index of the protected register to disturb |
| fault_bit_i | input | BIT_W | Test: bit position to flip |
| cfg_mismatch_rst_o | output | 1 | Configuration-mismatch reset request |

## Verification
A tracker stuck in the wrong step shows up at read-back of address 0 on the write after the next control write. The lock then moves on a broken sequence or fails to move on a correct one. A wrong lock or enable on the bank shows one cycle after a protected write, when the read-back either keeps the old value or takes the new one against the lock state. A faulty comparator or shadow shows up on the request pin exactly one cycle after a fault or a repair. The bench sweeps every key byte, every lock byte, every register and every bit for these cases.

// File: rtl/pinmap_guard_pkg.sv
package pinmap_guard_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h46;
  localparam logic [7:0] KEY_SECOND = 8'h57;
  localparam int         LOCK_POS   = 6;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } key_state_e;

endpackage

// File: rtl/pinmap_key_fsm.sv
module pinmap_key_fsm
  import pinmap_guard_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oneway_i,
  output logic              lock_o
);

  key_state_e state_q, state_d;
  logic       lock_q, lock_d;
  logic       is_first, is_second, clear_blocked;

  assign is_first      = (wdata_i == DATA_W'(KEY_FIRST));
  assign is_second     = (wdata_i == DATA_W'(KEY_SECOND));
  assign clear_blocked = oneway_i && lock_q && !wdata_i[LOCK_POS];

  always_comb begin
    state_d = state_q;
    lock_d  = lock_q;
    unique case (state_q)
      KEY_IDLE:  state_d = is_first ? KEY_HALF : KEY_IDLE;
      KEY_HALF: begin
        if (is_second)     state_d = KEY_ARMED;
        else if (is_first) state_d = KEY_HALF;
        else               state_d = KEY_IDLE;
      end
      KEY_ARMED: begin
        state_d = KEY_IDLE;
        if (!clear_blocked) lock_d = wdata_i[LOCK_POS];
      end
      default:   state_d = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KEY_IDLE;
      lock_q  <= 1'b0;
    end else if (ctl_wr_i) begin
      state_q <= state_d;
      lock_q  <= lock_d;
    end
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/pinmap_reg_bank.sv
module pinmap_reg_bank #(
  parameter int N_REG  = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int BIT_W  = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SEL_W-1:0]             wr_idx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         allow_i,
  input  logic                         fault_en_i,
  input  logic [SEL_W-1:0]             fault_idx_i,
  input  logic [BIT_W-1:0]             fault_bit_i,
  output logic [N_REG-1:0][DATA_W-1:0] live_o,
  output logic [N_REG-1:0][DATA_W-1:0] shadow_o
);

  logic [DATA_W-1:0] fault_mask;
  assign fault_mask = DATA_W'(1) << fault_bit_i;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    logic              legal_wr, fault_hit;
    logic [DATA_W-1:0] live_q, live_d, shad_q, shad_d;

    assign legal_wr  = wr_en_i && allow_i && (wr_idx_i == SEL_W'(g));
    assign fault_hit = fault_en_i && (fault_idx_i == SEL_W'(g));

    always_comb begin
      live_d = legal_wr ? wdata_i : live_q;
      if (fault_hit) live_d = live_d ^ fault_mask;
      shad_d = legal_wr ? wdata_i : shad_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q <= '0;
      end else if (legal_wr || fault_hit) begin
        live_q <= live_d;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shad_q <= '0;
      end else if (legal_wr) begin
        shad_q <= shad_d;
      end
    end

    assign live_o[g]   = live_q;
    assign shadow_o[g] = shad_q;
  end

endmodule

// File: rtl/pinmap_shadow_cmp.sv
module pinmap_shadow_cmp #(
  parameter int N_REG  = 8,
  parameter int DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_REG-1:0][DATA_W-1:0] live_i,
  input  logic [N_REG-1:0][DATA_W-1:0] shadow_i,
  output logic                         req_o
);

  logic [N_REG-1:0] diff;
  logic             req_d, req_q;

  for (genvar g = 0; g < N_REG; g++) begin : g_cmp
    assign diff[g] = (live_i[g] != shadow_i[g]);
  end

  always_comb req_d = |diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

endmodule

// File: rtl/pinmap_guard.sv
module pinmap_guard
  import pinmap_guard_pkg::*;
#(
  parameter  int N_IN   = 4,
  parameter  int N_OUT  = 4,
  parameter  int DATA_W = 8,
  localparam int N_REG  = N_IN + N_OUT,
  localparam int ADDR_W = $clog2(N_REG + 1),
  localparam int SEL_W  = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              oneway_cfg_i,
  input  logic              fault_en_i,
  input  logic [SEL_W-1:0]  fault_sel_i,
  input  logic [BIT_W-1:0]  fault_bit_i,
  output logic              cfg_mismatch_rst_o
);

  // reset: asynchronous assert, two-flop synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // address decode
  logic              ctl_hit, bank_hit, ctl_wr;
  logic [ADDR_W-1:0] addr_m1;
  logic [SEL_W-1:0]  bank_idx;
  logic              lock;

  assign ctl_hit  = (addr_i == '0);
  assign bank_hit = (addr_i != '0) && (addr_i <= ADDR_W'(N_REG));
  assign addr_m1  = addr_i - ADDR_W'(1);
  assign bank_idx = addr_m1[SEL_W-1:0];
  assign ctl_wr   = wr_en_i && ctl_hit;

  pinmap_key_fsm #(.DATA_W(DATA_W)) u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .ctl_wr_i (ctl_wr),
    .wdata_i  (wdata_i),
    .oneway_i (oneway_cfg_i),
    .lock_o   (lock)
  );

  logic [N_REG-1:0][DATA_W-1:0] live_w, shadow_w;

  pinmap_reg_bank #(
    .N_REG (N_REG),
    .DATA_W(DATA_W),
    .SEL_W (SEL_W),
    .BIT_W (BIT_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_en_i    (wr_en_i && bank_hit),
    .wr_idx_i   (bank_idx),
    .wdata_i    (wdata_i),
    .allow_i    (!lock),
    .fault_en_i (fault_en_i),
    .fault_idx_i(fault_sel_i),
    .fault_bit_i(fault_bit_i),
    .live_o     (live_w),
    .shadow_o   (shadow_w)
  );

  pinmap_shadow_cmp #(.N_REG(N_REG), .DATA_W(DATA_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .live_i  (live_w),
    .shadow_i(shadow_w),
    .req_o   (cfg_mismatch_rst_o)
  );

  // read-back
  always_comb begin
    rdata_o = '0;
    if (ctl_hit)       rdata_o[LOCK_POS] = lock;
    else if (bank_hit) rdata_o = live_w[bank_idx];
  end

endmodule

// File: rtl/pinmap_guard_chk.sv
module pinmap_guard_chk #(
  parameter int N_REG  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                    clk_i,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [DATA_W-1:0]       wdata,
  input logic                    oneway,
  input logic                    fault_en,
  input logic                    lock,
  input logic [N_REG*DATA_W-1:0] live,
  input logic [N_REG*DATA_W-1:0] shadow,
  input logic                    req
);

  // R5
  lock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en && addr == '0) |=> $stable(lock));

  // R8
  oneway_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (oneway && lock) |=> lock);

  // R4
  locked_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock && !fault_en) |=> $stable(live));

  // R3
  open_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!lock && wr_en && addr == ADDR_W'(1) && !fault_en) |=>
      (live[DATA_W-1:0] == $past(wdata)));

  // R10
  mismatch_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live != shadow) |=> req);

  // R10
  mismatch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (live == shadow) |=> !req);

endmodule

bind pinmap_guard pinmap_guard_chk #(
  .N_REG (N_REG),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en_i),
  .addr    (addr_i),
  .wdata   (wdata_i),
  .oneway  (oneway_cfg_i),
  .fault_en(fault_en_i),
  .lock    (lock),
  .live    (live_w),
  .shadow  (shadow_w),
  .req     (cfg_mismatch_rst_o)
);

// File: tb/pinmap_guard_bench.sv
module pinmap_guard_bench;

  localparam int N_IN   = 4;
  localparam int N_OUT  = 4;
  localparam int DATA_W = 8;
  localparam int N_REG  = N_IN + N_OUT;
  localparam int ADDR_W = $clog2(N_REG + 1);
  localparam int SEL_W  = $clog2(N_REG);
  localparam int BIT_W  = $clog2(DATA_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              oneway = 1'b0;
  logic              fault_en = 1'b0;
  logic [SEL_W-1:0]  fault_sel = '0;
  logic [BIT_W-1:0]  fault_bit = '0;
  logic              req;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [N_REG];

  always #2 clk = ~clk;

  pinmap_guard #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W)) u_pinmap_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .oneway_cfg_i(oneway),
    .fault_en_i(fault_en), .fault_sel_i(fault_sel), .fault_bit_i(fault_bit),
    .cfg_mismatch_rst_o(req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] v);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1 v = rdata;
  endtask

  task automatic key_write(input int d);
    wr(0, 8'h46); wr(0, 8'h57); wr(0, d);
  endtask

  function automatic logic [7:0] pat(input int k, input int r);
    return 8'((k * 37 + r * 101 + 5) & 255);
  endfunction

  task automatic check_bank(input string tag);
    logic [DATA_W-1:0] v;
    for (int k = 0; k < N_REG; k++) begin
      rd(k + 1, v);
      chk(tag, v, model[k]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < N_REG; k++) model[k] = 8'h00;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [DATA_W-1:0] v;
    do_reset();

    // R1: reset state
    rd(0, v); chk("R1 ctl", v, 0);
    check_bank("R1 bank");
    chk("R1 req", req, 0);

    // R3: unlocked writes to every register
    for (int k = 0; k < N_REG; k++) begin
      wr(k + 1, pat(k + 1, 0)); model[k] = pat(k + 1, 0);
      chk("R3 req", req, 0);
    end
    check_bank("R3 readback");

    // R2: unmapped addresses read 0 and writes there change nothing
    for (int a = N_REG + 1; a < (1 << ADDR_W); a++) begin
      wr(a, 8'hA5);
      rd(a, v); chk("R2 unmapped", v, 0);
    end
    check_bank("R2 bank intact");

    // R5: lock, control byte shows bit 6 only
    key_write(8'hFF);
    rd(0, v); chk("R2 R5 ctl=40", v, 8'h40);

    // R4 R7: many locked writes leave everything unchanged
    for (int k = 0; k < N_REG; k++) begin
      wr(k + 1, pat(k + 1, 1));
      chk("R4 req", req, 0);
    end
    check_bank("R4 locked");
    rd(0, v); chk("R7 lock kept", v, 8'h40);

    // R5: unlock; R7: several writes in one session
    key_write(8'h00);
    rd(0, v); chk("R5 unlock", v, 0);
    for (int k = 0; k < N_REG; k++) begin
      wr(k + 1, pat(k + 1, 2)); model[k] = pat(k + 1, 2);
    end
    check_bank("R7 session");
    rd(0, v); chk("R7 still open", v, 0);

    // R6: every wrong second byte cancels
    for (int x = 0; x < 256; x++) begin
      if (x == 8'h57 || x == 8'h46) continue;
      wr(0, 8'h46); wr(0, x); wr(0, 8'h40);
      rd(0, v); chk("R6 bad second byte", v, 0);
    end
    // R6: every wrong first byte cancels
    for (int x = 0; x < 256; x++) begin
      if (x == 8'h46) continue;
      wr(0, x); wr(0, 8'h57); wr(0, 8'h40);
      rd(0, v); chk("R6 bad first byte", v, 0);
    end
    // R6: repeated first byte restarts
    wr(0, 8'h46); wr(0, 8'h46); wr(0, 8'h57); wr(0, 8'h40);
    rd(0, v); chk("R6 restart", v, 8'h40);
    // R6: a write after the lock write needs a new sequence
    wr(0, 8'h00);
    rd(0, v); chk("R6 lone write", v, 8'h40);

    // R5: every third byte; lock follows bit 6
    for (int x = 0; x < 256; x++) begin
      key_write(x);
      rd(0, v); chk("R5 lock byte", v, 32'(x & 8'h40));
    end

    // R8: one-way mode
    key_write(8'h00);
    oneway = 1'b1;
    key_write(8'h00);
    rd(0, v); chk("R8 clear while clear", v, 0);
    key_write(8'h40);
    rd(0, v); chk("R8 set", v, 8'h40);
    key_write(8'h00);
    rd(0, v); chk("R8 clear blocked", v, 8'h40);
    key_write(8'hBF);
    rd(0, v); chk("R8 clear blocked bf", v, 8'h40);
    wr(1, 8'h3C);
    check_bank("R8 bank locked");

    // R1: reset reopens even in one-way mode
    do_reset();
    rd(0, v); chk("R1 after reset", v, 0);
    check_bank("R1 bank cleared");
    wr(2, 8'h5A); model[1] = 8'h5A;
    check_bank("R1 R8 first session");
    oneway = 1'b0;

    // R9: unlimited sessions
    for (int s = 0; s < 4; s++) begin
      key_write(8'h40);
      rd(0, v); chk("R9 set", v, 8'h40);
      key_write(8'h00);
      rd(0, v); chk("R9 clear", v, 0);
      wr(s + 1, pat(s, 3)); model[s] = pat(s, 3);
    end
    check_bank("R9 writes");

    // R10 R11: every register, every bit
    for (int g = 0; g < N_REG; g++) begin
      for (int b = 0; b < DATA_W; b++) begin
        @(negedge clk);
        fault_en = 1'b1; fault_sel = SEL_W'(g); fault_bit = BIT_W'(b);
        @(negedge clk);
        fault_en = 1'b0;
        chk("R10 req not yet", req, 0);
        @(negedge clk);
        chk("R10 req raised", req, 1);
        rd(g + 1, v); chk("R11 flipped bit", v, 32'(model[g] ^ (8'h01 << b)));
        chk("R10 req held", req, 1);
        wr(g + 1, pat(g, b)); model[g] = pat(g, b);
        chk("R10 req before clear", req, 1);
        @(negedge clk);
        chk("R10 req cleared", req, 0);
      end
    end
    check_bank("R10 repaired");

    // R4 R10: locked write cannot repair a disturbed register
    key_write(8'h40);
    @(negedge clk);
    fault_en = 1'b1; fault_sel = '0; fault_bit = BIT_W'(3);
    @(negedge clk);
    fault_en = 1'b0;
    wr(1, model[0]);
    repeat (2) @(negedge clk);
    chk("R4 R10 req stays", req, 1);
    rd(1, v); chk("R4 R11 locked value", v, 32'(model[0] ^ 8'h08));
    key_write(8'h00);
    wr(1, 8'h11); model[0] = 8'h11;
    repeat (2) @(negedge clk);
    chk("R10 repaired after unlock", req, 0);

    summary();
  end

endmodule